// File: doc/BRIEF.md
# Permission-Aware Set-Associative Tag Directory

This block is the tag side of a set-associative cache. Each set holds `WAYS` entries. Each entry stores a line tag and a two-bit access permission. The parent cache controller issues at most one command per cycle. Every command carries a line address. Access commands also carry a request kind: load, instruction fetch or store.

The directory answers one cycle later. The answer gives:
- hit or miss;
- whether a live matching entry exists, with its way and its permission;
- whether the set can take the line;
- the tag held in the set's least recently used way.

The controller uses these answers to allocate lines, change their permissions, drop them, and schedule evictions. Data storage and refill live elsewhere.

A hit is not decided by a valid bit. A line can be resident but unusable (Invalid), readable only, or fully writable. A freshly allocated line starts out Invalid. Recency is exact LRU, kept with per-way age counters in each set.

A small two-state machine watches for illegal commands:
- `DS_CLEAN` moves to `DS_FAULT` on an illegal command.
- `DS_FAULT` only leaves through reset.

The machine drives a sticky error flag.

Top module: `perm_tag_dir`

## Requirements
- R1: After reset every entry has permission code 0 (absent) and tag zero. Way w of every set has age w, so way `WAYS-1` is the initial victim. All response outputs and `err` are low.
- R2: Command codes on `cmd_op` are 0 access, 1 availability query, 2 allocate, 3 drop, 4 set permission, 5 victim probe; codes 6 and 7 change nothing. A command with `cmd_valid` high in cycle n produces `rsp_valid` and all response fields in cycle n+1, computed from the state before the command. With `cmd_valid` low, `rsp_valid` and all response fields are zero in the next cycle.
- R3: An entry matches when its tag equals the request tag and its permission is not 0. `rsp_match` reports a match, and `rsp_way` gives the lowest matching way (0 if none). `rsp_perm` gives that entry's permission (0 if none).
- R4: Permission codes are 0 absent, 1 Invalid, 2 ReadOnly, 3 ReadWrite. Request codes on `cmd_req` are 0 load, 1 instruction fetch, 2 store, and 3 behaves as a store. `rsp_hit` is high only for an access command whose matching entry is either of these:
  - code 3, for any request kind;
  - code 2, for a load or instruction fetch.
- R5: An access with a match makes the matching way most recent, even when the permission denies the access. A legal allocate makes the new way most recent. No other command changes recency.
- R6: A legal allocate writes the tag into the lowest-numbered way with permission 0 and sets that entry to Invalid (1). `rsp_way` reports that way.
- R7: `rsp_avail` is high when some way's tag equals the request tag, whatever its permission, or when some way has permission 0.
- R8: A legal drop sets the matching entry's permission to 0. A legal set-permission writes `cmd_perm` into the matching entry.
- R9: For every command, `rsp_victim_tag` is the tag held in the least recently used way of the addressed set.
- R10: The following are illegal: allocate when a match exists or no way has permission 0, and drop or set-permission without a match. An illegal command leaves tags, permissions and recency unchanged and raises `err`, which stays high until reset.
- R11: The set index is the low `SET_BITS` bits of `cmd_line`, and the stored tag is the remaining upper bits. Equal tags in different sets are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_line | input | LINE_W | Line address: upper bits tag, low bits set |
| cmd_req | input | 2 | Request kind for access commands |
| cmd_perm | input | 2 | New permission for set-permission |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Access allowed |
| rsp_match | output | 1 | Live matching entry exists |
| rsp_way | output | WAY_W | Matching way, or the chosen way for allocate |
| rsp_perm | output | 2 | Permission of the matching entry |
| rsp_avail | output | 1 | Set can hold the line |
| rsp_victim_tag | output | TAG_W | Tag in the LRU way of the set |
| err | output | 1 | Sticky illegal-command flag |

## Verification
The assertions check several properties on every cycle:
- the one-cycle response timing;
- a hit always needs a live ReadOnly or ReadWrite match;
- a store never hits a ReadOnly line;
- non-access commands never hit;
- a match always implies availability;
- the error flag is sticky.

Only the bench's reference model can show the stateful parts: the exact recency order, the victim choice after a mix of touches, the lowest-free-way allocation, and that illegal commands leave contents unchanged. It does so by comparing every response field against a behavioural model across directed and random command streams.

// File: rtl/perm_tag_dir_pkg.sv
package perm_tag_dir_pkg;

    typedef enum logic [2:0] {
        OP_ACCESS  = 3'd0,
        OP_AVAIL   = 3'd1,
        OP_ALLOC   = 3'd2,
        OP_DROP    = 3'd3,
        OP_SETPERM = 3'd4,
        OP_PROBE   = 3'd5
    } dir_op_e;

    typedef enum logic [1:0] {
        LP_ABSENT  = 2'd0,
        LP_INVALID = 2'd1,
        LP_READ    = 2'd2,
        LP_WRITE   = 2'd3
    } line_perm_e;

    typedef enum logic [1:0] {
        RQ_LOAD  = 2'd0,
        RQ_FETCH = 2'd1,
        RQ_STORE = 2'd2,
        RQ_RSVD  = 2'd3
    } req_kind_e;

    typedef enum logic {
        DS_CLEAN = 1'b0,
        DS_FAULT = 1'b1
    } dir_state_e;

    // Permission rule for an access that found a live entry
    function automatic logic perm_grants(input logic [1:0] perm, input logic [1:0] kind);
        return (perm == LP_WRITE) ||
               ((perm == LP_READ) && ((kind == RQ_LOAD) || (kind == RQ_FETCH)));
    endfunction

endpackage

// File: rtl/tdir_match.sv
module tdir_match
    import perm_tag_dir_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
    input  logic [WAYS-1:0][1:0]       way_perms,
    input  logic [TAG_W-1:0]           req_tag,
    output logic                       any_match,
    output logic [WAY_W-1:0]           match_way,
    output logic [1:0]                 match_perm,
    output logic                       any_tag_eq,
    output logic                       any_free,
    output logic [WAY_W-1:0]           free_way
);

    logic [WAYS-1:0] tag_eq;
    logic [WAYS-1:0] live;
    logic [WAYS-1:0] match_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign tag_eq[w]    = (way_tags[w] == req_tag);
        assign live[w]      = (way_perms[w] != LP_ABSENT);
        assign match_vec[w] = tag_eq[w] && live[w];
    end

    assign any_match  = |match_vec;
    assign any_tag_eq = |tag_eq;
    assign any_free   = ~&live;

    // Lowest index wins: scan from the top down
    always_comb begin
        match_way  = '0;
        match_perm = LP_ABSENT;
        free_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_vec[w]) begin
                match_way  = WAY_W'(w);
                match_perm = way_perms[w];
            end
            if (!live[w]) begin
                free_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/tdir_lru.sv
module tdir_lru #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int SET_W = 2,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] look_set,
    output logic [WAY_W-1:0] victim_way
);

    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAY_W-1:0] touched_age;

    assign touched_age = age_q[touch_set][touch_way];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    age_q[touch_set][w] <= '0;
                end else if (age_q[touch_set][w] < touched_age) begin
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[look_set][w] == OLDEST) begin
                victim_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/perm_tag_dir.sv
module perm_tag_dir
    import perm_tag_dir_pkg::*;
#(
    parameter  int SET_BITS = 2,
    parameter  int WAYS     = 4,
    parameter  int LINE_W   = 10,
    localparam int SETS     = 1 << SET_BITS,
    localparam int TAG_W    = LINE_W - SET_BITS,
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [LINE_W-1:0] cmd_line,
    input  logic [1:0]        cmd_req,
    input  logic [1:0]        cmd_perm,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_match,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [1:0]        rsp_perm,
    output logic              rsp_avail,
    output logic [TAG_W-1:0]  rsp_victim_tag,
    output logic              err
);

    // Address split
    logic [SET_BITS-1:0] set_idx;
    logic [TAG_W-1:0]    req_tag;
    assign set_idx = cmd_line[SET_BITS-1:0];
    assign req_tag = cmd_line[LINE_W-1:SET_BITS];

    // Entry storage
    logic [TAG_W-1:0] tag_q  [SETS][WAYS];
    logic [1:0]       perm_q [SETS][WAYS];

    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic [WAYS-1:0][1:0]       set_perms;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_tags[w]  = tag_q[set_idx][w];
            set_perms[w] = perm_q[set_idx][w];
        end
    end

    // Set lookup
    logic             any_match, any_tag_eq, any_free;
    logic [WAY_W-1:0] match_way, free_way, victim_way;
    logic [1:0]       match_perm;

    tdir_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .WAY_W (WAY_W)
    ) u_match (
        .way_tags   (set_tags),
        .way_perms  (set_perms),
        .req_tag    (req_tag),
        .any_match  (any_match),
        .match_way  (match_way),
        .match_perm (match_perm),
        .any_tag_eq (any_tag_eq),
        .any_free   (any_free),
        .free_way   (free_way)
    );

    // Command decode
    dir_op_e          op;
    logic             bad_cmd, do_alloc, do_drop, do_setperm, do_touch;
    logic [WAY_W-1:0] touch_way;

    assign op = dir_op_e'(cmd_op);

    always_comb begin
        bad_cmd    = 1'b0;
        do_alloc   = 1'b0;
        do_drop    = 1'b0;
        do_setperm = 1'b0;
        do_touch   = 1'b0;
        touch_way  = match_way;
        if (cmd_valid) begin
            unique case (op)
                OP_ACCESS: do_touch = any_match;
                OP_ALLOC: begin
                    if (any_match || !any_free) begin
                        bad_cmd = 1'b1;
                    end else begin
                        do_alloc  = 1'b1;
                        do_touch  = 1'b1;
                        touch_way = free_way;
                    end
                end
                OP_DROP: begin
                    bad_cmd = !any_match;
                    do_drop = any_match;
                end
                OP_SETPERM: begin
                    bad_cmd    = !any_match;
                    do_setperm = any_match;
                end
                default: ;
            endcase
        end
    end

    // Recency
    tdir_lru #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .SET_W (SET_BITS),
        .WAY_W (WAY_W)
    ) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (do_touch),
        .touch_set  (set_idx),
        .touch_way  (touch_way),
        .look_set   (set_idx),
        .victim_way (victim_way)
    );

    // Entry updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]  <= '0;
                    perm_q[s][w] <= LP_ABSENT;
                end
            end
        end else begin
            if (do_alloc) begin
                tag_q[set_idx][free_way]  <= req_tag;
                perm_q[set_idx][free_way] <= LP_INVALID;
            end
            if (do_drop) begin
                perm_q[set_idx][match_way] <= LP_ABSENT;
            end
            if (do_setperm) begin
                perm_q[set_idx][match_way] <= cmd_perm;
            end
        end
    end

    // Fault state machine
    dir_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DS_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_CLEAN: if (bad_cmd) state_d = DS_FAULT;
            DS_FAULT: state_d = DS_FAULT;
            default:  state_d = DS_FAULT;
        endcase
    end

    assign err = (state_q == DS_FAULT);

    // Registered response
    always_ff @(posedge clk) begin
        if (!rst_n || !cmd_valid) begin
            rsp_valid      <= 1'b0;
            rsp_hit        <= 1'b0;
            rsp_match      <= 1'b0;
            rsp_way        <= '0;
            rsp_perm       <= LP_ABSENT;
            rsp_avail      <= 1'b0;
            rsp_victim_tag <= '0;
        end else begin
            rsp_valid      <= 1'b1;
            rsp_hit        <= (op == OP_ACCESS) && any_match && perm_grants(match_perm, cmd_req);
            rsp_match      <= any_match;
            rsp_way        <= (op == OP_ALLOC) ? free_way : match_way;
            rsp_perm       <= match_perm;
            rsp_avail      <= any_tag_eq || any_free;
            rsp_victim_tag <= tag_q[set_idx][victim_way];
        end
    end

endmodule

// File: rtl/perm_tag_dir_chk.sv
module perm_tag_dir_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic [1:0] cmd_req,
    input logic       rsp_valid,
    input logic       rsp_hit,
    input logic       rsp_match,
    input logic [1:0] rsp_perm,
    input logic       rsp_avail,
    input logic       err
);

    assert_rsp_follows_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);

    assert_quiet_without_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);

    assert_no_perm_without_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_match |-> (rsp_perm == 2'd0));

    assert_hit_needs_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_match && (rsp_perm == 2'd2 || rsp_perm == 2'd3)));

    assert_store_misses_readonly_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd0 && cmd_req == 2'd2) |=> !(rsp_hit && rsp_perm == 2'd2));

    assert_hit_only_on_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op != 3'd0) |=> !rsp_hit);

    assert_match_means_avail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_match |-> rsp_avail);

    assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

endmodule

bind perm_tag_dir perm_tag_dir_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_req   (cmd_req),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_match (rsp_match),
    .rsp_perm  (rsp_perm),
    .rsp_avail (rsp_avail),
    .err       (err)
);

// File: tb/perm_tag_dir_tb.sv
`timescale 1ns/1ps
module perm_tag_dir_tb;

    localparam int SET_BITS = 2;
    localparam int WAYS     = 4;
    localparam int LINE_W   = 10;
    localparam int SETS     = 1 << SET_BITS;
    localparam int TAG_W    = LINE_W - SET_BITS;
    localparam int WAY_W    = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [LINE_W-1:0] cmd_line = '0;
    logic [1:0]        cmd_req = '0;
    logic [1:0]        cmd_perm = '0;
    logic              rsp_valid, rsp_hit, rsp_match, rsp_avail, err;
    logic [WAY_W-1:0]  rsp_way;
    logic [1:0]        rsp_perm;
    logic [TAG_W-1:0]  rsp_victim_tag;

    always #4 clk = ~clk;  // 125 MHz

    perm_tag_dir #(.SET_BITS(SET_BITS), .WAYS(WAYS), .LINE_W(LINE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_line(cmd_line), .cmd_req(cmd_req), .cmd_perm(cmd_perm),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_match(rsp_match),
        .rsp_way(rsp_way), .rsp_perm(rsp_perm), .rsp_avail(rsp_avail),
        .rsp_victim_tag(rsp_victim_tag), .err(err)
    );

    int checks = 0;
    int fails  = 0;

    // Reference model state
    int m_tag  [SETS][WAYS];
    int m_perm [SETS][WAYS];
    int m_age  [SETS][WAYS];
    int m_err;

    // Pending expectation
    int pend = 0;
    int e_valid, e_hit, e_match, e_way, e_perm, e_avail, e_vtag, e_op;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                m_tag[s][w]  = 0;
                m_perm[s][w] = 0;
                m_age[s][w]  = w;
            end
        end
        m_err = 0;
    endtask

    task automatic touch(input int s, input int w);
        int a;
        a = m_age[s][w];
        for (int v = 0; v < WAYS; v++) begin
            if (v == w) m_age[s][v] = 0;
            else if (m_age[s][v] < a) m_age[s][v]++;
        end
    endtask

    task automatic compare_pending();
        if (pend != 0) begin
            chk("R2", "rsp_valid", int'(rsp_valid), e_valid);
            if (e_valid != 0) begin
                chk("R4", "rsp_hit", int'(rsp_hit), e_hit);
                chk("R3/R11", "rsp_match", int'(rsp_match), e_match);
                chk((e_op == 2) ? "R6" : "R3", "rsp_way", int'(rsp_way), e_way);
                chk("R8", "rsp_perm", int'(rsp_perm), e_perm);
                chk("R7", "rsp_avail", int'(rsp_avail), e_avail);
                chk("R5/R9", "rsp_victim_tag", int'(rsp_victim_tag), e_vtag);
            end
            chk("R10", "err", int'(err), m_err);
        end
    endtask

    task automatic issue(input int op, input int tag, input int s, input int rq, input int np);
        int mw, ff, eq, vic;
        @(negedge clk);
        compare_pending();
        mw = -1; ff = -1; eq = 0; vic = 0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (m_tag[s][w] == tag && m_perm[s][w] != 0) mw = w;
            if (m_perm[s][w] == 0) ff = w;
            if (m_tag[s][w] == tag) eq = 1;
            if (m_age[s][w] == WAYS - 1) vic = w;
        end
        e_valid = 1;
        e_op    = op;
        e_match = (mw >= 0) ? 1 : 0;
        e_perm  = (mw >= 0) ? m_perm[s][mw] : 0;
        e_hit   = (op == 0 && mw >= 0 &&
                   (e_perm == 3 || (e_perm == 2 && (rq == 0 || rq == 1)))) ? 1 : 0;
        e_way   = (op == 2) ? ((ff >= 0) ? ff : 0) : ((mw >= 0) ? mw : 0);
        e_avail = (eq != 0 || ff >= 0) ? 1 : 0;
        e_vtag  = m_tag[s][vic];
        case (op)
            0: if (mw >= 0) touch(s, mw);
            2: begin
                if (mw >= 0 || ff < 0) m_err = 1;
                else begin
                    m_tag[s][ff] = tag;
                    m_perm[s][ff] = 1;
                    touch(s, ff);
                end
            end
            3: if (mw < 0) m_err = 1; else m_perm[s][mw] = 0;
            4: if (mw < 0) m_err = 1; else m_perm[s][mw] = np;
            default: ;
        endcase
        pend      = 1;
        cmd_valid = 1'b1;
        cmd_op    = 3'(op);
        cmd_line  = LINE_W'((tag << SET_BITS) | s);
        cmd_req   = 2'(rq);
        cmd_perm  = 2'(np);
    endtask

    task automatic idle();
        @(negedge clk);
        compare_pending();
        e_valid   = 0;
        pend      = 1;
        cmd_valid = 1'b0;
        cmd_op    = '0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, fails);
        $finish;
    end

    initial begin : stim
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "rsp_valid", int'(rsp_valid), 0);
        chk("R1", "rsp_victim_tag", int'(rsp_victim_tag), 0);
        chk("R1", "err", int'(err), 0);

        issue(5, 0, 0, 0, 0);        // R1/R9: probe empty set, victim way 3, tag 0
        issue(0, 8'h11, 1, 0, 0);    // miss on empty
        issue(2, 8'h11, 1, 0, 0);    // R6: way 0
        issue(2, 8'h12, 1, 0, 0);    // way 1
        issue(2, 8'h13, 1, 0, 0);    // way 2
        issue(2, 8'h14, 1, 0, 0);    // way 3
        issue(5, 8'h15, 1, 0, 0);    // R9: victim tag 0x11
        issue(0, 8'h11, 1, 0, 0);    // R5: Invalid match, miss, still touched
        issue(5, 8'h15, 1, 0, 0);    // R5: victim now 0x12
        issue(4, 8'h12, 1, 0, 2);    // R8: ReadOnly
        issue(0, 8'h12, 1, 0, 0);    // R4: load hit
        issue(0, 8'h12, 1, 1, 0);    // R4: fetch hit
        issue(0, 8'h12, 1, 2, 0);    // R4: store miss
        issue(4, 8'h13, 1, 0, 3);    // ReadWrite
        issue(0, 8'h13, 1, 2, 0);    // R4: store hit
        issue(0, 8'h13, 1, 3, 0);    // R4: reserved kind acts as store
        issue(1, 8'h15, 1, 0, 0);    // R7: full, absent tag -> 0
        issue(1, 8'h11, 1, 0, 0);    // R7: present -> 1
        issue(3, 8'h12, 1, 0, 0);    // R8: drop way 1
        issue(1, 8'h12, 1, 0, 0);    // R7: tag equal though absent
        issue(2, 8'h16, 1, 0, 0);    // R6: reuses way 1
        issue(0, 8'h11, 2, 0, 0);    // R11: same tag other set misses
        issue(6, 8'h11, 1, 0, 0);    // R2: reserved op no effect
        idle();
        idle();
        issue(2, 8'h11, 1, 0, 0);    // R10: alloc present -> err
        issue(0, 8'h11, 1, 0, 0);    // R10: entry untouched
        issue(3, 8'h77, 3, 0, 0);    // R10: drop absent
        issue(2, 8'h20, 1, 0, 0);    // R10: set full
        issue(5, 8'h20, 1, 0, 0);
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 7) == 0) idle();
            else issue(int'($urandom_range(0, 6)), int'($urandom_range(0, 5)),
                       int'($urandom_range(0, SETS - 1)), int'($urandom_range(0, 3)),
                       int'($urandom_range(0, 3)));
        end
        idle();
        idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, fails);
        $finish;
    end

endmodule